// File: doc/BRIEF.md
# Serial Multiprocessor Address Filter

This block sits behind the bit-level receiver of a UART and decides whether each completed received byte should raise the receive flag. In the multiprocessor mode a serial link carries address bytes that target one or several stations. Every receiver checks each address byte against its own station address and ignores bytes meant for another station.

Two programmable registers, a station address and a care mask, are loaded through a small write port. A byte is accepted on an individual match when it agrees with the station address in every bit the mask selects. It is also accepted on a broadcast match when it has a one in every position where the station address or the mask has a one. Filtering is active only when the serial mode field is nonzero and the multiprocessor enable is high. In every other case each byte is accepted. An accepted byte sets a sticky receive flag, which software clears with a strobe. A one-cycle match pulse reports each decision.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset, `addr_rd` and `mask_rd` read 0, `rx_flag` is 0 and `match_pulse` is 0.
- R2: A cycle with `cfg_wr` high loads `cfg_wdata` into the station address when `cfg_sel` is 0, or into the mask when `cfg_sel` is 1. The new value is visible on `addr_rd` or `mask_rd` after the next rising edge, and the other register keeps its value.
- R3: When `mode` is 0 or `multi_en` is 0, every byte strobed by `rx_valid` is accepted.
- R4: With filtering active, a byte is accepted when `(rx_data & mask) == (addr & mask)`.
- R5: With filtering active, a byte is accepted when `(rx_data & B) == B`, where `B = addr | mask`.
- R6: With filtering active, a byte that matches neither R4 nor R5 is rejected. `match_pulse` stays 0 and `rx_flag` keeps its previous value.
- R7: With the mask at 0 and filtering active, every byte is accepted.
- R8: Acceptance sets `rx_flag` one edge after the `rx_valid` cycle. The flag stays set until a cycle with `flag_clr` high clears it. If a byte is accepted in the same cycle as a clear, the flag ends up set.
- R9: `match_pulse` is high for exactly the one cycle after each accepted byte and is low in every other cycle. The decision uses the register values held before any configuration write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 = station address, 1 = mask |
| cfg_wdata | input | DATA_W | Configuration write data |
| addr_rd | output | DATA_W | Current station address |
| mask_rd | output | DATA_W | Current care mask |
| mode | input | MODE_W | Serial mode field; zero disables filtering |
| multi_en | input | 1 | Multiprocessor enable |
| rx_valid | input | 1 | One-cycle strobe: a received byte is complete |
| rx_data | input | DATA_W | Received byte |
| flag_clr | input | 1 | Software clear of the receive flag |
| rx_flag | output | 1 | Sticky receive flag |
| match_pulse | output | 1 | One-cycle pulse for each accepted byte |

## Verification
The assertions check the following on every cycle:
- accepted bytes under disabled filtering, individual matches and broadcast matches produce a pulse;
- a byte that matches nothing leaves a clear flag clear;
- the flag holds between strobes;
- there is no pulse without a preceding strobe;
- configuration writes land in the selected register.

The bench scenarios are needed for the rest:
- the combined effect of random address, mask and byte patterns against an independent acceptance model;
- a rejected byte leaving an already set flag set;
- a set and a clear arriving in the same cycle;
- the reset values of the registers.

// File: rtl/maf_pkg.sv
package maf_pkg;

    typedef enum logic {
        SEL_STATION = 1'b0,
        SEL_MASK    = 1'b1
    } cfg_target_e;

endpackage

// File: rtl/maf_cfg_regs.sv
module maf_cfg_regs
    import maf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  cfg_target_e       sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] station,
    output logic [DATA_W-1:0] mask
);

    typedef struct packed {
        logic [DATA_W-1:0] station;
        logic [DATA_W-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (sel)
                SEL_STATION: cfg_d.station = wdata;
                SEL_MASK:    cfg_d.mask    = wdata;
                default:     cfg_d         = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign station = cfg_q.station;
    assign mask    = cfg_q.mask;

    // R2: a write lands in the selected register only
    p_wr_station_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_STATION) |=> (station == $past(wdata) && $stable(mask)));
    p_wr_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_MASK) |=> (mask == $past(wdata) && $stable(station)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(station) && $stable(mask)));

endmodule

// File: rtl/maf_match.sv
module maf_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] station,
    input  logic [DATA_W-1:0] mask,
    input  logic              filter_on,
    output logic              accept
);

    logic [DATA_W-1:0] indiv_ok;
    logic [DATA_W-1:0] bcast_ok;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // bit agrees with station address, or is a don't-care
        assign indiv_ok[i] = ~mask[i] | ~(rx_byte[i] ^ station[i]);
        // bit is not required by the broadcast pattern, or is present
        assign bcast_ok[i] = ~(station[i] | mask[i]) | rx_byte[i];
    end

    logic indiv_hit;
    logic bcast_hit;

    always_comb begin
        indiv_hit = &indiv_ok;
        bcast_hit = &bcast_ok;
        accept    = !filter_on || indiv_hit || bcast_hit;
    end

endmodule

// File: rtl/maf_flag.sv
module maf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic accept,
    input  logic flag_clr,
    output logic flag,
    output logic pulse
);

    typedef struct packed {
        logic flag;
        logic pulse;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = rx_valid && accept;
        if (rx_valid && accept) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign pulse = st_q.pulse;

    // R8: flag holds without a strobe or a clear
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !flag_clr) |=> $stable(flag));
    // R8: set wins over a simultaneous clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && accept && flag_clr) |=> flag);
    // R8: a clear alone empties the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !rx_valid) |=> !flag);
    // R9: no pulse without a preceding strobe
    p_no_stray_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !pulse);
    // R9: pulse always accompanies a set flag
    p_pulse_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);

endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
    import maf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] addr_rd,
    output logic [DATA_W-1:0] mask_rd,
    input  logic [MODE_W-1:0] mode,
    input  logic              multi_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              flag_clr,
    output logic              rx_flag,
    output logic              match_pulse
);

    logic [DATA_W-1:0] station_q;
    logic [DATA_W-1:0] mask_q;
    logic              filter_on;
    logic              accept;
    cfg_target_e       sel_e;

    assign sel_e     = cfg_target_e'(cfg_sel);
    assign filter_on = (mode != '0) && multi_en;

    maf_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .sel     (sel_e),
        .wdata   (cfg_wdata),
        .station (station_q),
        .mask    (mask_q)
    );

    maf_match #(.DATA_W(DATA_W)) u_match (
        .rx_byte   (rx_data),
        .station   (station_q),
        .mask      (mask_q),
        .filter_on (filter_on),
        .accept    (accept)
    );

    maf_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .accept   (accept),
        .flag_clr (flag_clr),
        .flag     (rx_flag),
        .pulse    (match_pulse)
    );

    assign addr_rd = station_q;
    assign mask_rd = mask_q;

    // R3: filtering off accepts every byte
    p_no_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (mode == '0 || !multi_en)) |=> (match_pulse && rx_flag));
    // R4: individual match accepted
    p_indiv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && ((rx_data ^ addr_rd) & mask_rd) == '0) |=> match_pulse);
    // R5: broadcast match accepted
    p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_data & (addr_rd | mask_rd)) == (addr_rd | mask_rd))
            |=> match_pulse);
    // R6: unmatched byte with filtering on leaves a clear flag clear
    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode != '0 && multi_en && !rx_flag
         && ((rx_data ^ addr_rd) & mask_rd) != '0
         && (rx_data & (addr_rd | mask_rd)) != (addr_rd | mask_rd))
            |=> (!match_pulse && !rx_flag));

endmodule

// File: tb/mp_addr_filter_test.sv
module mp_addr_filter_test;

    localparam int DW = 8;
    localparam int MW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] addr_rd, mask_rd;
    logic [MW-1:0] mode = '0;
    logic          multi_en = 1'b0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          flag_clr = 1'b0;
    logic          rx_flag, match_pulse;

    int total = 0;
    int bad = 0;

    logic [DW-1:0] m_addr = '0;
    logic [DW-1:0] m_mask = '0;
    logic          m_flag = 1'b0;

    always #5 clk = ~clk;

    mp_addr_filter #(.DATA_W(DW), .MODE_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .addr_rd(addr_rd), .mask_rd(mask_rd),
        .mode(mode), .multi_en(multi_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .flag_clr(flag_clr), .rx_flag(rx_flag),
        .match_pulse(match_pulse)
    );

    function automatic logic model_accept(input logic [MW-1:0] md, input logic en,
                                          input logic [DW-1:0] a, input logic [DW-1:0] m,
                                          input logic [DW-1:0] b);
        logic [DW-1:0] bc;
        bc = a | m;
        if (md == '0 || !en) return 1'b1;
        if ((b & m) == (a & m)) return 1'b1;
        if ((b & bc) == bc) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic sel, input logic [DW-1:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel) m_mask = v; else m_addr = v;
        chk("R2 addr", {24'd0, addr_rd}, {24'd0, m_addr});
        chk("R2 mask", {24'd0, mask_rd}, {24'd0, m_mask});
    endtask

    task automatic send(input string req, input logic [DW-1:0] b, input logic clr);
        logic acc;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; flag_clr = clr;
        acc = model_accept(mode, multi_en, m_addr, m_mask, b);
        if (acc) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
        @(negedge clk);
        rx_valid = 1'b0; flag_clr = 1'b0;
        chk({req, " pulse"}, {31'd0, match_pulse}, {31'd0, acc});
        chk({req, " flag"}, {31'd0, rx_flag}, {31'd0, m_flag});
        @(negedge clk);
        chk("R9 pulse one cycle", {31'd0, match_pulse}, 32'd0);
        chk("R8 flag held", {31'd0, rx_flag}, {31'd0, m_flag});
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_flag = 1'b0;
        chk("R8 clear", {31'd0, rx_flag}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 addr", {24'd0, addr_rd}, 32'd0);
        chk("R1 mask", {24'd0, mask_rd}, 32'd0);
        chk("R1 flag", {31'd0, rx_flag}, 32'd0);
        chk("R1 pulse", {31'd0, match_pulse}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: mask zero, filtering active
        mode = 2'd2; multi_en = 1'b1;
        wr_cfg(1'b0, 8'hA5);
        send("R7 mask zero", 8'h3C, 1'b0);
        clear_flag();

        // R4 / R5 / R6
        wr_cfg(1'b0, 8'h30);
        wr_cfg(1'b1, 8'hF0);
        send("R4 individual", 8'h3C, 1'b0);
        clear_flag();
        send("R5 broadcast", 8'hF7, 1'b0);
        clear_flag();
        send("R6 reject clear flag", 8'h5C, 1'b0);
        send("R4 set again", 8'h31, 1'b0);
        send("R6 reject set flag", 8'h5C, 1'b0);

        // R8: set and clear together
        send("R8 set wins", 8'h30, 1'b1);
        clear_flag();
        send("R6 reject with clear", 8'h5C, 1'b1);

        // R3: filtering disabled
        mode = 2'd0; multi_en = 1'b1;
        send("R3 mode zero", 8'h5C, 1'b0);
        clear_flag();
        mode = 2'd1; multi_en = 1'b0;
        send("R3 enable low", 8'h5C, 1'b0);
        clear_flag();

        // R9: config write in same cycle as byte uses old values
        mode = 2'd3; multi_en = 1'b1;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h5C;
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h00;
        @(negedge clk);
        rx_valid = 1'b0; cfg_wr = 1'b0; m_mask = 8'h00;
        chk("R9 old config used", {31'd0, match_pulse}, 32'd0);
        chk("R2 mask write", {24'd0, mask_rd}, 32'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 8) == 0) wr_cfg(1'($urandom % 2), DW'($urandom));
            mode = MW'($urandom);
            multi_en = ($urandom % 4) != 0;
            send("R4/R5/R6 random", DW'($urandom), 1'($urandom % 3 == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule